// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Function Decoder

This block is a purely combinational arithmetic-logic unit for a simple processor datapath. It contains its own control decoder. The main controller supplies a 2-bit operation class. For register-format instructions it also supplies the 6-bit function field. The decoder turns these into a 4-bit control code. The datapath then applies that code to two 32-bit operands and produces a result and a zero flag.

The control code is made of four fields, most significant bit first:

- operand-A inversion;
- operand-B inversion;
- a 2-bit function select.

Subtraction reuses the adder: operand B is inverted and the carry-in is taken from the B-inversion bit. NOR reuses the AND gate: both operands are inverted. Set-on-less-than uses the same subtraction, with its sign corrected for signed overflow.

The block holds no state. Every output follows its inputs within the same evaluation. Data enters and leaves as plain, always-valid pins. There is no valid/ready handshake, so there is no back-pressure to honour. A caller that wants the branch-equal test selects the branch class and reads the zero flag.

Top module: `alu_fn_unit`

## Requirements
- R1: The datapath uses the control codes below, with fields {invA, invB, sel[1:0]} and sel 00=AND, 01=OR, 10=add, 11=set-on-less-than:

  | Code | Operation |
  |------|-----------|
  | 0000 | AND |
  | 0001 | OR |
  | 0010 | add |
  | 0110 | subtract |
  | 0111 | set-on-less-than |

- R2: Operation class 00 always yields code 0010 (addition), whatever the function field holds.
- R3: Operation class 01 always yields code 0110 (subtraction), whatever the function field holds.
- R4: Under operation class 10, the function field is decoded as follows:

  | Function field | Operation |
  |----------------|-----------|
  | 100000 | add |
  | 100010 | subtract |
  | 100100 | AND |
  | 100101 | OR |
  | 101010 | set-on-less-than |

- R5: Under class 10, any other function field yields the add code 0010. Class 11 decodes exactly as class 10.
- R6: The most significant bit of the code produced by the decoder is always 0.
- R7: Subtraction is computed as A + ~B + 1 and wraps modulo 2^32.
- R8: Set-on-less-than compares the operands as signed values, including pairs whose difference overflows. It returns 1 in bit 0 when A < B and 0 otherwise, and all other result bits are 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0. Under class 01 it is therefore 1 exactly when the operands are equal.
- R10: Code 1100 computes NOR, that is ~(A | B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of a register-format instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Result of the selected operation |
| zero | output | 1 | Result is all zeros |
| ctl_code | output | 4 | Control code produced by the decoder |

## Verification
Subtraction and the zero flag act in the same evaluation when a branch-equal test is made. The bench provokes this with equal operands, with operands that differ only in the sign bit, and with random pairs under class 01. It expects the flag only when the operands match.

Set-on-less-than and the zero flag also coincide, because a false comparison produces an all-zero result. The bench feeds overflow-prone pairs such as the most negative value against the most positive one. It checks both bit 0 and the flag against a signed comparison made in the bench.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;
  typedef struct packed {
    logic       inv_a;
    logic       inv_b;
    logic [1:0] sel;
  } alu_ctl_t;

  localparam logic [1:0] SEL_AND = 2'b00;
  localparam logic [1:0] SEL_OR  = 2'b01;
  localparam logic [1:0] SEL_ADD = 2'b10;
  localparam logic [1:0] SEL_SLT = 2'b11;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BEQ = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_fn_pkg::*;
#(
  parameter int CLS_W = 2,
  parameter int FN_W  = 6
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  funct,
  output alu_ctl_t         ctl
);
  logic [3:0] fn_code;

  // Second level: function field, used only by register-format classes
  always_comb begin
    unique case (funct)
      FN_ADD:  fn_code = CODE_ADD;
      FN_SUB:  fn_code = CODE_SUB;
      FN_AND:  fn_code = CODE_AND;
      FN_OR:   fn_code = CODE_OR;
      FN_SLT:  fn_code = CODE_SLT;
      default: fn_code = CODE_ADD;
    endcase
  end

  // First level: operation class
  always_comb begin
    unique case (op_class)
      CLS_MEM: ctl = alu_ctl_t'(CODE_ADD);
      CLS_BEQ: ctl = alu_ctl_t'(CODE_SUB);
      default: ctl = alu_ctl_t'(fn_code);
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  // Signed overflow: carry into the sign bit differs from carry out of it
  assign ovf = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_fn_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_ctl_t     ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero
);
  logic [W-1:0] a_eff, b_eff, sum;
  logic         ovf, less;

  assign a_eff = ctl.inv_a ? ~a : a;
  assign b_eff = ctl.inv_b ? ~b : b;

  // Carry-in taken from the B-inversion bit turns add into subtract
  alu_adder #(.W(W)) adder_i (
    .x(a_eff), .y(b_eff), .cin(ctl.inv_b), .sum(sum), .ovf(ovf)
  );

  assign less = sum[W-1] ^ ovf;

  always_comb begin
    unique case (ctl.sel)
      SEL_AND: result = a_eff & b_eff;
      SEL_OR:  result = a_eff | b_eff;
      SEL_ADD: result = sum;
      default: result = {{(W-1){1'b0}}, less};
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (ctl.sel == SEL_SLT)
      assert_slt_bits_R8: assert (result[W-1:1] == '0)
        else $error("slt upper bits set");
  end
endmodule

// File: rtl/alu_fn_unit.sv
module alu_fn_unit
  import alu_fn_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_class,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         zero,
  output logic [3:0]   ctl_code
);
  alu_ctl_t ctl;

  alu_ctl_decode #(.CLS_W(2), .FN_W(6)) dec_i (
    .op_class(op_class), .funct(funct), .ctl(ctl)
  );

  alu_datapath #(.W(W)) dp_i (
    .ctl(ctl), .a(opnd_a), .b(opnd_b), .result(result), .zero(zero)
  );

  assign ctl_code = ctl;

  always_comb begin
    assert_msb_zero_R6: assert (ctl_code[3] == 1'b0)
      else $error("decoder produced inversion of A");
    assert_zero_flag_R9: assert (zero == (result == '0))
      else $error("zero flag disagrees with result");
    if (op_class == CLS_MEM)
      assert_mem_add_R2: assert (result == opnd_a + opnd_b)
        else $error("memory class did not add");
    if (op_class == CLS_BEQ)
      assert_beq_equal_R3: assert (zero == (opnd_a == opnd_b))
        else $error("branch class zero flag wrong");
  end
endmodule

// File: tb/alu_fn_unit_tb.sv
module alu_fn_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] opnd_a, opnd_b, result, core_res;
  logic        zero, core_zero;
  logic [3:0]  ctl_code, core_ctl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  alu_fn_unit dut_i (
    .op_class(op_class), .funct(funct), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .zero(zero), .ctl_code(ctl_code)
  );

  alu_datapath #(.W(32)) core_i (
    .ctl(core_ctl), .a(opnd_a), .b(opnd_b), .result(core_res), .zero(core_zero)
  );

  function automatic logic [3:0] exp_code(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    case (f)
      6'b100000: return 4'b0010;
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return 32'hx;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Applies a vector to the top, then checks code, result and zero flag
  task automatic run_top(input string tag, input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] a, input logic [31:0] b);
    logic [3:0]  k;
    logic [31:0] r;
    @(negedge clk);
    op_class = c; funct = f; opnd_a = a; opnd_b = b;
    #2;
    k = exp_code(c, f);
    r = exp_res(k, a, b);
    chk({tag, " code"}, {28'd0, ctl_code}, {28'd0, k});
    chk({tag, " result"}, result, r);
    chk({tag, " zero R9"}, {31'd0, zero}, {31'd0, (r == 32'd0)});
  endtask

  task automatic run_core(input string tag, input logic [3:0] k,
                          input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    core_ctl = k; opnd_a = a; opnd_b = b;
    #2;
    chk(tag, core_res, exp_res(k, a, b));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog got=%0d exp<=%0d", cycles, 100000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    op_class = 2'b00; funct = 6'd0; opnd_a = 32'd0; opnd_b = 32'd0; core_ctl = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("reset R2 idle result", result, 32'd0);
    chk("reset R9 idle zero", {31'd0, zero}, 32'd1);

    // R2, R3: class overrides the function field
    run_top("R2 mem add", 2'b00, 6'b100100, 32'h0000_1000, 32'h0000_0064);
    run_top("R2 mem add wrap", 2'b00, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0002);
    run_top("R3 beq equal", 2'b01, 6'b100101, 32'h1234_5678, 32'h1234_5678);
    run_top("R3 beq sign diff", 2'b01, 6'b100000, 32'h8000_0000, 32'h0000_0000);
    // R4: each supported function under class 10
    run_top("R4 add", 2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001);
    run_top("R4 sub", 2'b10, 6'b100010, 32'h0000_0005, 32'h0000_0003);
    run_top("R4 and", 2'b10, 6'b100100, 32'hF0F0_FF00, 32'h0FF0_F0F0);
    run_top("R4 or", 2'b10, 6'b100101, 32'hF000_0000, 32'h0000_000F);
    run_top("R4 slt", 2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0000);
    // R5: unsupported field and class 11
    run_top("R5 unsupported", 2'b10, 6'b000000, 32'h0000_0011, 32'h0000_0022);
    run_top("R5 unsupported2", 2'b10, 6'b100111, 32'h0000_0011, 32'h0000_0022);
    run_top("R5 class11 sub", 2'b11, 6'b100010, 32'h0000_0010, 32'h0000_0010);
    run_top("R5 class11 slt", 2'b11, 6'b101010, 32'h0000_0001, 32'h0000_0002);
    // R7: subtraction wrap
    run_top("R7 sub wrap", 2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001);
    run_top("R7 sub min", 2'b01, 6'b000000, 32'h8000_0000, 32'h0000_0001);
    // R8: signed corners, including overflowing differences
    run_top("R8 min lt max", 2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF);
    run_top("R8 max lt min", 2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000);
    run_top("R8 equal", 2'b10, 6'b101010, 32'h8000_0000, 32'h8000_0000);
    run_top("R8 neg pair", 2'b10, 6'b101010, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    // R1, R10: datapath driven with explicit codes, including NOR
    run_core("R1 core and", 4'b0000, 32'hAAAA_5555, 32'hFFFF_0000);
    run_core("R1 core or", 4'b0001, 32'hAAAA_0000, 32'h0000_5555);
    run_core("R1 core add", 4'b0010, 32'h8000_0000, 32'h8000_0000);
    run_core("R1 core sub", 4'b0110, 32'h0000_0003, 32'h0000_0007);
    run_core("R1 core slt", 4'b0111, 32'h8000_0001, 32'h7FFF_FFFF);
    run_core("R10 nor", 4'b1100, 32'hF0F0_0000, 32'h0000_0F0F);
    run_core("R10 nor zero", 4'b1100, 32'h0000_0000, 32'h0000_0000);

    // Constrained random mix, R6 implied by code check (bit 3 expected 0)
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  c;
      logic [5:0]  f;
      logic [31:0] a, b;
      c = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 5))
        0: f = 6'b100000;
        1: f = 6'b100010;
        2: f = 6'b100100;
        3: f = 6'b100101;
        4: f = 6'b101010;
        default: f = 6'($urandom);
      endcase
      a = $urandom;
      b = ($urandom_range(0, 7) == 0) ? a : $urandom;
      run_top("R6 random", c, f, a, b);
    end
    for (int i = 0; i < 500; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      run_core("R10 random nor", 4'b1100, a, b);
      run_core("R1 random slt", 4'b0111, a, b);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule